// File: doc/BRIEF.md
# ADC-to-Byte-Bus Transfer Controller

This block moves one 16-bit sample from an external analog-to-digital converter onto an 8-bit processor bus. When asked to, it fires a one-clock start pulse at the converter. It then waits for the converter to signal that the conversion has finished, and it latches the word at that moment. The word then leaves the block as two bytes, high byte first.

A single select line, driven by the state machine, steers a row of 2-to-1 multiplexers between the two halves of the held word. The block places each byte on the bus with a valid strobe and keeps it there until the bus answers with ready. A one-cycle done pulse closes a good transfer.

An optional watchdog on the converter limits the wait. If the converter stays silent for a programmed number of cycles, the block returns to idle and raises an error pulse instead.

Top module: `adc_byte_xfer`

## Requirements
- R1: Reset is synchronous and active high. In every cycle after a reset edge, `conv_start_o`, `bus_valid_o`, `done_o` and `err_o` are all low.
- R2: A `req_i` seen high at a clock edge while the block is idle makes `conv_start_o` high for exactly the one clock cycle after that edge.
- R3: While a transfer is in progress, `req_i` is ignored. No new start pulse appears until the transfer ends in `done_o` or `err_o`.
- R4: The block captures `conv_data_i` at the clock edge where `conv_done_i` is first seen high during the wait. Changes to `conv_data_i` after that edge do not change the bytes sent.
- R5: In the cycle after the capture edge, `bus_valid_o` is high and `bus_data_o` carries bits 15:8 of the captured word.
- R6: While `bus_valid_o` is high and `bus_ready_i` is low, `bus_valid_o` and `bus_data_o` hold their values. The cycle after the high byte is accepted (valid and ready both high at an edge), `bus_data_o` carries bits 7:0 with `bus_valid_o` high.
- R7: The cycle after the low byte is accepted, `done_o` is high for exactly one cycle and `bus_valid_o` is low.
- R8: With `tmo_limit_i` = L > 0, if `conv_done_i` is low at all of the first L clock edges of the wait, then in the cycle after the L-th edge `err_o` is high for one cycle, nothing is put on the bus and the block is idle. If `conv_done_i` is high at the L-th edge, the word is still accepted.
- R9: With `tmo_limit_i` = 0, the wait has no limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Transfer request, acted on only in idle |
| tmo_limit_i | input | TMO_W | Wait limit in cycles, 0 means no limit |
| conv_start_o | output | 1 | One-cycle start pulse to the converter |
| conv_done_i | input | 1 | Converter reports its word is ready |
| conv_data_i | input | 2*BYTE_W | Converter output word |
| bus_data_o | output | BYTE_W | Byte presented on the processor bus |
| bus_valid_o | output | 1 | Byte on the bus is valid |
| bus_ready_i | input | 1 | Bus accepts the current byte |
| done_o | output | 1 | One-cycle pulse after the low byte is accepted |
| err_o | output | 1 | One-cycle pulse on a wait timeout |

## Verification
The start pulse is due one cycle after the request edge. The high byte is due one cycle after the capture edge. The low byte is due one cycle after the high byte is accepted, and the done pulse one cycle after the low byte is accepted. A timeout error is due one cycle after the L-th silent edge of the wait.

The driver changes inputs only on falling edges. It samples each of these outputs at the falling edge that follows the rising edge on which it is due, so each result is checked in the cycle the requirements name. Separately, a monitor pops the expected bytes from a queue at every accepting handshake. Between handshakes it confirms that a stalled byte does not move.

// File: rtl/adc_byte_xfer.sv
module adc_byte_xfer #(
  parameter int BYTE_W = 8,
  parameter int TMO_W  = 16,
  parameter bit TMO_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_i,
  input  logic [TMO_W-1:0]    tmo_limit_i,
  output logic                conv_start_o,
  input  logic                conv_done_i,
  input  logic [2*BYTE_W-1:0] conv_data_i,
  output logic [BYTE_W-1:0]   bus_data_o,
  output logic                bus_valid_o,
  input  logic                bus_ready_i,
  output logic                done_o,
  output logic                err_o
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam logic [TMO_W-1:0] ONE = TMO_W'(1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_WAIT, S_HI, S_LO} state_t;

  state_t            state;
  logic [WORD_W-1:0] hold_q;
  logic [TMO_W-1:0]  wait_cnt;
  logic              sel_hi;
  logic              tmo_hit;

  assign sel_hi       = (state == S_HI);
  assign conv_start_o = (state == S_START);
  assign bus_valid_o  = (state == S_HI) || (state == S_LO);
  assign tmo_hit      = TMO_EN && (tmo_limit_i != '0) && (wait_cnt == tmo_limit_i - ONE);

  for (genvar b = 0; b < BYTE_W; b++) begin : g_mux
    assign bus_data_o[b] = sel_hi ? hold_q[BYTE_W + b] : hold_q[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      hold_q   <= '0;
      wait_cnt <= '0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (state)
        S_IDLE:  if (req_i) state <= S_START;
        S_START: begin
          wait_cnt <= '0;
          state    <= S_WAIT;
        end
        S_WAIT: begin
          if (conv_done_i) begin
            hold_q <= conv_data_i;
            state  <= S_HI;
          end else if (tmo_hit) begin
            err_o <= 1'b1;
            state <= S_IDLE;
          end else begin
            wait_cnt <= wait_cnt + ONE;
          end
        end
        S_HI: if (bus_ready_i) state <= S_LO;
        S_LO: if (bus_ready_i) begin
          done_o <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> !conv_start_o && !bus_valid_o && !done_o && !err_o);

  p_start_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    conv_start_o |=> !conv_start_o);

  p_start_from_idle_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_start_o) |-> $past(state == S_IDLE && req_i));

  p_capture_to_hi_r5: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT && conv_done_i) |=> bus_valid_o && bus_data_o == $past(conv_data_i[WORD_W-1:BYTE_W]));

  p_byte_held_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_valid_o && !bus_ready_i) |=> bus_valid_o && $stable(bus_data_o));

  p_lo_after_hi_r6: assert property (@(posedge clk) disable iff (rst)
    (state == S_HI && bus_ready_i) |=> state == S_LO);

  p_done_after_lo_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(state == S_LO && bus_ready_i) && !bus_valid_o);

  p_err_quiet_bus_r8: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past(state == S_WAIT) && !bus_valid_o && !done_o);

  p_no_overlap_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({conv_start_o, bus_valid_o, done_o, err_o}));
endmodule

// File: tb/adc_byte_xfer_tb_top.sv
module adc_byte_xfer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_i = 1'b0;
  logic [15:0] tmo_limit_i = 16'd50;
  logic        conv_start_o;
  logic        conv_done_i = 1'b0;
  logic [15:0] conv_data_i = 16'h0;
  logic [7:0]  bus_data_o;
  logic        bus_valid_o;
  logic        bus_ready_i = 1'b0;
  logic        done_o;
  logic        err_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  adc_byte_xfer dut_i (
    .clk(clk), .rst(rst), .req_i(req_i), .tmo_limit_i(tmo_limit_i),
    .conv_start_o(conv_start_o), .conv_done_i(conv_done_i), .conv_data_i(conv_data_i),
    .bus_data_o(bus_data_o), .bus_valid_o(bus_valid_o), .bus_ready_i(bus_ready_i),
    .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard compare on each accepting handshake, stall stability otherwise
  logic [7:0] prev_data;
  bit         prev_stall = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall) begin
        chk(bus_valid_o, "R6 valid held", int'(bus_valid_o), 1);
        chk(bus_data_o == prev_data, "R6 data held", int'(bus_data_o), int'(prev_data));
      end
      if (bus_valid_o && bus_ready_i) begin
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected byte", int'(bus_data_o), 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(bus_data_o == e, "R4/R5/R6 byte order", int'(bus_data_o), int'(e));
        end
      end
      prev_stall = bus_valid_o && !bus_ready_i;
      prev_data  = bus_data_o;
    end
  end

  task automatic start_req();
    @(negedge clk) req_i = 1'b1;
    @(negedge clk) req_i = 1'b0;
    chk(conv_start_o == 1'b1, "R2 start pulse", int'(conv_start_o), 1);
    @(negedge clk);
    chk(conv_start_o == 1'b0, "R2 pulse one cycle", int'(conv_start_o), 0);
  endtask

  task automatic xfer(input logic [15:0] w, input int wait_n, input int rdy_hi, input int rdy_lo);
    exp_q.push_back(w[15:8]);
    exp_q.push_back(w[7:0]);
    start_req();
    req_i = 1'b1;
    for (int i = 0; i < wait_n; i++) begin
      @(negedge clk);
      chk(!conv_start_o && !bus_valid_o, "R3 busy request ignored", int'(conv_start_o), 0);
    end
    req_i = 1'b0;
    conv_data_i = w;
    conv_done_i = 1'b1;
    @(negedge clk);
    conv_done_i = 1'b0;
    conv_data_i = ~w;
    chk(bus_valid_o && bus_data_o == w[15:8], "R5 high byte first", int'(bus_data_o), int'(w[15:8]));
    repeat (rdy_hi) @(negedge clk);
    bus_ready_i = 1'b1;
    @(negedge clk);
    bus_ready_i = 1'b0;
    chk(bus_valid_o && bus_data_o == w[7:0], "R4 R6 low byte next", int'(bus_data_o), int'(w[7:0]));
    repeat (rdy_lo) @(negedge clk);
    bus_ready_i = 1'b1;
    @(negedge clk);
    bus_ready_i = 1'b0;
    chk(done_o && !bus_valid_o, "R7 done pulse", int'(done_o), 1);
    @(negedge clk);
    chk(!done_o && !conv_start_o, "R7 done one cycle", int'(done_o), 0);
  endtask

  task automatic timeout_run(input logic [15:0] lim);
    tmo_limit_i = lim;
    start_req();
    for (int i = 1; i < int'(lim); i++) begin
      @(negedge clk);
      chk(!err_o, "R8 no early error", int'(err_o), 0);
    end
    @(negedge clk);
    chk(err_o && !bus_valid_o, "R8 error on limit", int'(err_o), 1);
    @(negedge clk);
    chk(!err_o && !bus_valid_o && !conv_start_o, "R8 back to idle", int'(err_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!conv_start_o && !bus_valid_o && !done_o && !err_o, "R1 reset quiet",
        int'({conv_start_o, bus_valid_o, done_o, err_o}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!conv_start_o && !bus_valid_o, "R1 idle after reset", int'(conv_start_o), 0);

    xfer(16'hA55A, 0, 0, 0);
    xfer(16'h1234, 3, 2, 4);
    xfer(16'hFF00, 7, 5, 1);
    xfer(16'h00FF, 1, 0, 3);

    timeout_run(16'd5);                 // R8 timeout
    tmo_limit_i = 16'd5;
    xfer(16'hBEEF, 4, 1, 1);            // R8 done on the L-th edge is accepted
    timeout_run(16'd1);
    tmo_limit_i = 16'd0;
    xfer(16'hC3A7, 300, 1, 0);          // R9 no limit
    tmo_limit_i = 16'd50;

    // R1: reset in the middle of a transfer
    @(negedge clk) req_i = 1'b1;
    @(negedge clk) req_i = 1'b0;
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    chk(!conv_start_o && !bus_valid_o && !err_o, "R1 reset mid transfer", int'(bus_valid_o), 0);
    rst = 1'b0;
    conv_done_i = 1'b1;
    @(negedge clk);
    conv_done_i = 1'b0;
    chk(!bus_valid_o, "R1 idle ignores converter", int'(bus_valid_o), 0);
    xfer(16'h5A5A, 2, 0, 0);

    chk(exp_q.size() == 0, "R6 all bytes delivered", exp_q.size(), 0);
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule